// File: doc/BRIEF.md
# Flash command snooper with dual-lane bit striper

This block sits between a byte transmit queue and a set of parallel SPI byte lanes that talk to matched flash memories. At the start of each chip-select window it reads the first outgoing byte as a flash opcode. From that opcode it works out how many header bytes follow (address, mode and dummy), and those header bytes go out on every lane unchanged. When the header count runs out, the block switches to striping. In striping, each transfer step takes one byte per lane from the queue and spreads their bits across the lanes. Bytes that come back from the lanes go through the reverse mapping before they are pushed to the receive queue.

The queue owner presents the head bytes of the transmit queue and how many are available, then raises a step request. The block reports how many bytes to pop in that same cycle. It drives the lane bytes with a one-cycle go pulse on the next cycle. When the lanes return their bytes, it pushes the decoded result to the receive side, or flags an overflow if the receive queue is full. The serializer that shifts bits onto the pins lies outside this block.

Top module: `flash_stripe_snooper`

## Requirements
- R1: After reset, and on the cycle after `cs_active_i` is seen low, the block is back in the opcode-checking state, so the next transferred byte is decoded as an opcode.
- R2: In the checking state, opcode 0x03, 0x02, 0xA2 or 0x32 is followed by 3 header bytes. Opcode 0x0B, 0x3B, 0x6B or 0xBB is followed by 4. Opcode 0xEB is followed by 6. All header bytes are sent unstriped.
- R3: Any other opcode leads to a pass-through state. In that state every byte is sent unstriped until `cs_active_i` goes low.
- R4: Each header byte transferred lowers the remaining count by one. The transfer step right after the last header byte is a striping step.
- R5: A non-striping step pops 1 byte (`tx_pop_o`=1), and the head byte `tx_bytes_i[7:0]` is sent on every lane. Its receive result pushes one byte, lane 0's, to `rx_data_o[7:0]` with `rx_cnt_o`=1.
- R6: A striping step pops LANES bytes. Bit b of lane i's output byte is bit (n div LANES) of head byte (n mod LANES), where n = 8i+b. Head byte j is `tx_bytes_i[8j+:8]` and lane i is `lane_tx_o[8i+:8]`.
- R7: The receive result of a striping step applies the inverse of the R6 mapping to `lane_rx_i` and pushes LANES bytes in order (`rx_cnt_o`=LANES).
- R8: If `rx_full_i` is high when `lane_rx_valid_i` arrives, nothing is pushed (`rx_push_o`=0) and `overflow_o` is high in that cycle.
- R9: A step for which `tx_avail_i` is less than the bytes it needs pops nothing, sends nothing and leaves the snoop state as it was. On the next cycle it pulses `underflow_o`, unless `linear_mode_i` is high.
- R10: After a step that pops bytes, `lane_go_o` pulses high for exactly the next cycle, with the lane bytes held on `lane_tx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_active_i | input | 1 | High while any chip select is asserted |
| linear_mode_i | input | 1 | Suppresses underflow events |
| step_i | input | 1 | Transfer step request |
| tx_avail_i | input | CW | Number of bytes in the transmit queue (saturating at LANES) |
| tx_bytes_i | input | 8*LANES | Head bytes of the transmit queue, head at bits 7:0 |
| tx_pop_o | output | CW | Bytes to pop this cycle |
| lane_tx_o | output | 8*LANES | Byte for each lane, lane i at bits 8i+7:8i |
| lane_go_o | output | 1 | Lane bytes valid pulse |
| underflow_o | output | 1 | Transmit underflow event |
| lane_rx_i | input | 8*LANES | Bytes returned by the lanes |
| lane_rx_valid_i | input | 1 | Lane return valid |
| rx_full_i | input | 1 | Receive queue full |
| rx_push_o | output | 1 | Push to the receive queue |
| rx_data_o | output | 8*LANES | Bytes to push, first at bits 7:0 |
| rx_cnt_o | output | CW | Number of valid bytes in rx_data_o |
| overflow_o | output | 1 | Receive overflow event |

## Verification
The assertions assume the following about the inputs:
- `tx_avail_i` never exceeds the real queue level.
- A lane return belongs to the most recent step that popped bytes and arrives before the next such step.
- `cs_active_i` stays high throughout a command.

The stimulus follows these rules. It issues each step, checks the launched lane bytes, then returns a lane result before the next step. It drops chip select only between commands, with no step pending.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {SN_CHECK, SN_COUNT, SN_PASS, SN_STRIPE} snoop_e;

  localparam int unsigned HDR_W = 3;

  // header bytes after an opcode; 0 means unknown opcode
  function automatic logic [HDR_W-1:0] hdr_len(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: hdr_len = 3'd3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: hdr_len = 3'd4;
      8'hEB:                      hdr_len = 3'd6;
      default:                    hdr_len = 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/snoop_fsm.sv
module snoop_fsm
  import snoop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_active_i,
  input  logic       adv_i,
  input  logic [7:0] byte_i,
  output logic       striping_o
);
  snoop_e           state_q, state_d;
  logic [HDR_W-1:0] cnt_q, cnt_d;
  logic [HDR_W-1:0] len;

  assign len = hdr_len(byte_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!cs_active_i) begin
      state_d = SN_CHECK;
    end else if (adv_i) begin
      unique case (state_q)
        SN_CHECK: begin
          cnt_d   = len;
          state_d = (len == '0) ? SN_PASS : SN_COUNT;
        end
        SN_COUNT: begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == HDR_W'(1)) state_d = SN_STRIPE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SN_CHECK;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign striping_o = (state_q == SN_STRIPE);

  a_r1_idle_to_check: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_active_i |=> state_q == SN_CHECK);
  a_r4_last_hdr_stripes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_active_i && adv_i && state_q == SN_COUNT && cnt_q == HDR_W'(1) |=> striping_o);
  a_r3_pass_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_active_i && state_q == SN_PASS |=> state_q == SN_PASS);
endmodule

// File: rtl/bit_stripe.sv
module bit_stripe #(
  parameter int unsigned LANES   = 2,
  parameter bit          INVERSE = 1'b0
) (
  input  logic [8*LANES-1:0] d_i,
  output logic [8*LANES-1:0] q_o
);
  localparam int unsigned NB = 8 * LANES;

  for (genvar n = 0; n < NB; n++) begin : g_bit
    // n is the flat output position; source byte n%LANES, bit n/LANES
    localparam int unsigned SRC = 8 * (n % LANES) + n / LANES;
    if (INVERSE) begin : g_inv
      assign q_o[SRC] = d_i[n];
    end else begin : g_fwd
      assign q_o[n] = d_i[SRC];
    end
  end
endmodule

// File: rtl/flash_stripe_snooper.sv
module flash_stripe_snooper #(
  parameter int unsigned LANES = 2,
  localparam int unsigned CW   = $clog2(LANES + 1),
  localparam int unsigned DW   = 8 * LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_active_i,
  input  logic          linear_mode_i,
  input  logic          step_i,
  input  logic [CW-1:0] tx_avail_i,
  input  logic [DW-1:0] tx_bytes_i,
  output logic [CW-1:0] tx_pop_o,
  output logic [DW-1:0] lane_tx_o,
  output logic          lane_go_o,
  output logic          underflow_o,
  input  logic [DW-1:0] lane_rx_i,
  input  logic          lane_rx_valid_i,
  input  logic          rx_full_i,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_data_o,
  output logic [CW-1:0] rx_cnt_o,
  output logic          overflow_o
);
  localparam logic [CW-1:0] LANES_C = CW'(LANES);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic          striping;
  logic [CW-1:0] need;
  logic          take;
  logic [DW-1:0] fwd_bytes, inv_bytes, lane_d;
  logic [DW-1:0] lane_q;
  logic          go_q, under_q, striped_q;

  assign need = striping ? LANES_C : ONE_C;
  assign take = step_i && (tx_avail_i >= need);
  assign tx_pop_o = take ? need : '0;

  snoop_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_active_i(cs_active_i),
    .adv_i      (take && !striping),
    .byte_i     (tx_bytes_i[7:0]),
    .striping_o (striping)
  );

  bit_stripe #(.LANES(LANES), .INVERSE(1'b0)) i_fwd (
    .d_i(tx_bytes_i),
    .q_o(fwd_bytes)
  );

  bit_stripe #(.LANES(LANES), .INVERSE(1'b1)) i_inv (
    .d_i(lane_rx_i),
    .q_o(inv_bytes)
  );

  assign lane_d = striping ? fwd_bytes : {LANES{tx_bytes_i[7:0]}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q    <= '0;
      go_q      <= 1'b0;
      under_q   <= 1'b0;
      striped_q <= 1'b0;
    end else begin
      go_q    <= take;
      under_q <= step_i && !take && !linear_mode_i;
      if (take) begin
        lane_q    <= lane_d;
        striped_q <= striping;
      end
    end
  end

  assign lane_tx_o   = lane_q;
  assign lane_go_o   = go_q;
  assign underflow_o = under_q;

  assign rx_push_o  = lane_rx_valid_i && !rx_full_i;
  assign overflow_o = lane_rx_valid_i && rx_full_i;
  assign rx_data_o  = striped_q ? inv_bytes : {{(DW-8){1'b0}}, lane_rx_i[7:0]};
  assign rx_cnt_o   = striped_q ? LANES_C : ONE_C;

  a_r10_go_follows_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o != '0 |=> lane_go_o);
  a_r9_under_no_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> !lane_go_o);
  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |-> !rx_push_o);
  a_r6_pop_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    striping && tx_pop_o != '0 |-> tx_pop_o == LANES_C);
  a_r5_single_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !striping |-> tx_pop_o <= ONE_C);
endmodule

// File: tb/test_flash_stripe_snooper.sv
module test_flash_stripe_snooper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, lin = 1'b0, step = 1'b0;
  logic [1:0] avail = '0;
  logic [15:0] txb = '0;
  logic [1:0] pop;
  logic [15:0] ltx;
  logic       go, under;
  logic [15:0] lrx = '0;
  logic       lrx_v = 1'b0, full = 1'b0;
  logic       push, over;
  logic [15:0] rxd;
  logic [1:0] rxc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_stripe_snooper #(.LANES(2)) i_flash_stripe_snooper (
    .clk_i(clk), .rst_ni(rst_n), .cs_active_i(cs), .linear_mode_i(lin),
    .step_i(step), .tx_avail_i(avail), .tx_bytes_i(txb), .tx_pop_o(pop),
    .lane_tx_o(ltx), .lane_go_o(go), .underflow_o(under),
    .lane_rx_i(lrx), .lane_rx_valid_i(lrx_v), .rx_full_i(full),
    .rx_push_o(push), .rx_data_o(rxd), .rx_cnt_o(rxc), .overflow_o(over)
  );

  task automatic check(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // spread input byte j bit k to flat position 2k+j
  function automatic logic [15:0] spread(input logic [15:0] d);
    logic [15:0] o = '0;
    for (int j = 0; j < 2; j++)
      for (int k = 0; k < 8; k++) o[2*k + j] = d[8*j + k];
    return o;
  endfunction

  function automatic logic [15:0] gather(input logic [15:0] d);
    logic [15:0] o = '0;
    for (int j = 0; j < 2; j++)
      for (int k = 0; k < 8; k++) o[8*j + k] = d[2*k + j];
    return o;
  endfunction

  task automatic step_chk(input string r, input logic [1:0] av, input logic [15:0] b,
                          input int epop, input logic [15:0] elane, input int eunder);
    @(negedge clk);
    avail = av; txb = b; step = 1'b1;
    #1 check(r, "tx_pop", pop, epop);
    @(negedge clk);
    step = 1'b0; avail = '0;
    check(r, "lane_go", go, epop != 0);
    if (epop != 0) check(r, "lane_tx", ltx, elane);
    check(r, "underflow", under, eunder);
  endtask

  task automatic rx_chk(input string r, input logic [15:0] l, input logic f,
                        input int epush, input int eover, input logic [15:0] ed, input int ecnt);
    @(negedge clk);
    lrx = l; lrx_v = 1'b1; full = f;
    #1;
    check(r, "rx_push", push, epush);
    check(r, "overflow", over, eover);
    if (epush != 0) begin
      check(r, "rx_data", rxd, ed);
      check(r, "rx_cnt", rxc, ecnt);
    end
    @(negedge clk);
    lrx_v = 1'b0; full = 1'b0;
  endtask

  task automatic cs_cycle();
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1;
  endtask

  // broadcast byte, head byte sent on both lanes
  task automatic bcast(input string r, input logic [7:0] b);
    step_chk(r, 2'd2, {8'h77, b}, 1, {b, b}, 0);
  endtask

  // {b0, b1, rx lane0, rx lane1, striped}
  localparam logic [39:0] VEC [8] = '{
    {8'h0B, 8'hEE, 8'h5A, 8'h11, 8'd0},
    {8'h12, 8'h00, 8'hC3, 8'h22, 8'd0},
    {8'h34, 8'h00, 8'h01, 8'h33, 8'd0},
    {8'h56, 8'h00, 8'h80, 8'h44, 8'd0},
    {8'h00, 8'h00, 8'h7E, 8'h55, 8'd0},
    {8'hF0, 8'h0F, 8'hAA, 8'h55, 8'd1},
    {8'hFF, 8'h00, 8'h55, 8'h55, 8'd1},
    {8'h3C, 8'hA5, 8'h12, 8'hE7, 8'd1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #1;
    check("R1", "lane_go at reset", go, 0);
    check("R1", "underflow at reset", under, 0);
    check("R1", "tx_pop at reset", pop, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; cs = 1'b1;

    // table: opcode 0x0B (R2 four header bytes), then striping (R4, R6, R7)
    foreach (VEC[v]) begin
      logic [15:0] b  = {VEC[v][31:24], VEC[v][39:32]};
      logic [15:0] l  = {VEC[v][15:8],  VEC[v][23:16]};
      if (VEC[v][0]) begin
        step_chk("R6", 2'd2, b, 2, spread(b), 0);
        rx_chk("R7", l, 1'b0, 1, 0, gather(l), 2);
      end else begin
        step_chk("R5", 2'd2, b, 1, {b[7:0], b[7:0]}, 0);
        rx_chk("R5", l, 1'b0, 1, 0, {8'h00, l[7:0]}, 1);
      end
    end

    // R9 underflow in striping: one byte short, no pop, state kept
    step_chk("R9", 2'd1, 16'h1234, 0, 16'h0, 1);
    lin = 1'b1;
    step_chk("R9", 2'd0, 16'h0, 0, 16'h0, 0);
    lin = 1'b0;
    step_chk("R9", 2'd2, 16'h0FF0, 2, spread(16'h0FF0), 0);

    // R8 overflow drops the result
    rx_chk("R8", 16'hBEEF, 1'b1, 0, 1, 16'h0, 0);

    // R1 chip select release returns to checking, R2 opcode 0x03 -> 3 bytes
    cs_cycle();
    bcast("R2", 8'h03);
    for (int i = 0; i < 3; i++) bcast("R2", 8'(i + 8'h40));
    step_chk("R4", 2'd2, 16'hC381, 2, spread(16'hC381), 0);

    // R3 unknown opcode: pass-through for many bytes
    cs_cycle();
    bcast("R3", 8'h9F);
    for (int i = 0; i < 8; i++) bcast("R3", 8'(i + 8'h10));
    rx_chk("R3", 16'h6699, 1'b0, 1, 0, 16'h0099, 1);

    // R2 opcode 0xEB -> 6 header bytes, and underflow in header keeps count
    cs_cycle();
    bcast("R2", 8'hEB);
    for (int i = 0; i < 3; i++) bcast("R2", 8'(i + 8'h20));
    step_chk("R9", 2'd0, 16'h0, 0, 16'h0, 1);
    for (int i = 0; i < 3; i++) bcast("R2", 8'(i + 8'h30));
    step_chk("R4", 2'd2, 16'h5AA5, 2, spread(16'h5AA5), 0);
    rx_chk("R7", 16'h9C3E, 1'b0, 1, 0, gather(16'h9C3E), 2);

    // R10 go pulse lasts one cycle
    @(negedge clk);
    check("R10", "lane_go low after pulse", go, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule